// File: doc/BRIEF.md
# Four-Channel SPI Interrupt Status Collector

This block gathers the one-cycle event pulses produced by the channels of a four-channel SPI controller. Each pulse is latched into a sticky bit of a 32-bit status word. Each channel owns a fixed 4-bit lane in that word. A receive overflow bit exists for channel 0 only, and two module-wide bits record end of word count and slave wake-up. Software clears a pending bit by writing a 1 to it. A parallel enable word, using the same bit positions, selects which pending bits raise the single combined interrupt line.

Events from a channel are captured only while that channel is enabled. Receive overflow is captured only while the module is a slave and channel 0 is enabled. A test strobe sets every implemented status bit at once, so the interrupt wiring can be exercised without real traffic. Positions that carry no event always read as zero. The status and enable words are always visible on read-data outputs, and reading them has no side effects.

Top module: `spi_irq_collect`

## Requirements
- R1: A status write with a 1 in an implemented bit clears that bit on the next clock. Bits written as 0 keep their value.
- R2: In lane c (c = 0..3), a transmit-empty pulse sets bit 4c, a transmit-underflow pulse sets bit 4c+1 and a receive-full pulse sets bit 4c+2. Each bit reads 1 from the cycle after the pulse until it is cleared.
- R3: A receive-overflow pulse sets bit 3 only when slave mode is high and channel 0 is enabled. In every other case it leaves the status at zero.
- R4: An end-of-word-count pulse sets bit 17 and a wake-up pulse sets bit 16, whatever the channel enables are.
- R5: Transmit-empty, transmit-underflow and receive-full pulses of a disabled channel change no status bit.
- R6: The enable register is written whole by an enable write and reads back with the same bit positions as the status register. Positions with no event read 0.
- R7: A test-force strobe sets all implemented status bits on the next clock, giving 0x0003777F.
- R8: Bits 7, 11, 15 and 18..31 of the status word always read 0, whatever is written or forced.
- R9: The interrupt output is a register. It is high one cycle after the status and enable registers share a set bit, and low one cycle after they share none.
- R10: If an event pulse and a write-1-to-clear hit the same bit in the same cycle, the bit stays set.
- R11: After reset, status, enable and interrupt are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_enable | input | 4 | Per-channel enable; gates that channel's events |
| slave_mode | input | 1 | High when the controller runs as a slave |
| ev_tx_empty | input | 4 | Per-channel transmit-holding-empty pulse |
| ev_tx_undr | input | 4 | Per-channel transmit underflow pulse |
| ev_rx_full | input | 4 | Per-channel receive-holding-full pulse |
| ev_rx_ovf | input | 1 | Channel 0 receive overflow pulse |
| ev_eow | input | 1 | End of word count pulse |
| ev_wake | input | 1 | Slave wake-up pulse |
| test_force | input | 1 | Sets every implemented status bit |
| sts_wr | input | 1 | Status write strobe (write 1 to clear) |
| en_wr | input | 1 | Enable register write strobe |
| wdata | input | 32 | Write data for both registers |
| sts_rdata | output | 32 | Current status word |
| en_rdata | output | 32 | Current enable word |
| irq | output | 1 | Combined interrupt level |

## Verification
The lane layout is swept over every channel and every event type, once with only the target channel enabled and once with all other channels enabled. The first shows each pulse landing on its own bit. The second shows that a disabled channel's events are dropped even while its neighbours are active. The overflow bit is tried under all four combinations of slave mode and channel-0 enable. The interrupt path is swept over all 32 enable positions with the status forced full, which separates implemented from unimplemented positions and confirms the one-cycle lag. Partial clears and same-cycle set/clear collisions check that only written-1 bits fall and that a new event outranks a clear.

// File: rtl/spi_irq_pkg.sv
// Shared constants for the SPI interrupt collector.
// Assumes at most four channels, each with a 4-bit lane starting at bit 0.
package spi_irq_pkg;
    localparam int STS_W        = 32;
    localparam int LANE_W       = 4;
    localparam int OFS_TX_EMPTY = 0;
    localparam int OFS_TX_UNDR  = 1;
    localparam int OFS_RX_FULL  = 2;
    localparam int BIT_RX_OVF   = 3;
    localparam int BIT_WAKE     = 16;
    localparam int BIT_EOW      = 17;

    // Bits that carry an event for a given channel count.
    function automatic logic [STS_W-1:0] impl_mask(input int n_ch);
        logic [STS_W-1:0] m;
        m = '0;
        for (int c = 0; c < n_ch; c++) begin
            m[LANE_W*c + OFS_TX_EMPTY] = 1'b1;
            m[LANE_W*c + OFS_TX_UNDR]  = 1'b1;
            m[LANE_W*c + OFS_RX_FULL]  = 1'b1;
        end
        m[BIT_RX_OVF] = 1'b1;
        m[BIT_WAKE]   = 1'b1;
        m[BIT_EOW]    = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/spi_irq_evt_map.sv
// Maps raw event pulses onto status bit positions, applying channel gating,
// the slave-only overflow rule and the test-force strobe.
// Assumes event inputs are single-cycle pulses in the clk domain.
module spi_irq_evt_map
    import spi_irq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_enable,
    input  logic              slave_mode,
    input  logic [NUM_CH-1:0] ev_tx_empty,
    input  logic [NUM_CH-1:0] ev_tx_undr,
    input  logic [NUM_CH-1:0] ev_rx_full,
    input  logic              ev_rx_ovf,
    input  logic              ev_eow,
    input  logic              ev_wake,
    input  logic              test_force,
    output logic [STS_W-1:0]  set_vec
);
    localparam logic [STS_W-1:0] MASK = impl_mask(NUM_CH);

    logic [NUM_CH-1:0][2:0] lane_hit;

    // One gated lane per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        assign lane_hit[c][0] = ch_enable[c] & ev_tx_empty[c];
        assign lane_hit[c][1] = ch_enable[c] & ev_tx_undr[c];
        assign lane_hit[c][2] = ch_enable[c] & ev_rx_full[c];
    end

    // Assemble the set vector from lanes, module-wide events and force.
    always_comb begin
        set_vec = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            set_vec[LANE_W*c + OFS_TX_EMPTY] = lane_hit[c][0];
            set_vec[LANE_W*c + OFS_TX_UNDR]  = lane_hit[c][1];
            set_vec[LANE_W*c + OFS_RX_FULL]  = lane_hit[c][2];
        end
        set_vec[BIT_RX_OVF] = ev_rx_ovf & slave_mode & ch_enable[0];
        set_vec[BIT_WAKE]   = ev_wake;
        set_vec[BIT_EOW]    = ev_eow;
        if (test_force) set_vec = set_vec | MASK;
    end

    AST_OVF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!(slave_mode && ch_enable[0]) && !test_force) |-> !set_vec[BIT_RX_OVF]); // R3
    AST_CH0_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_enable[0] && !test_force) |-> (set_vec[2:0] == 3'b000)); // R5
endmodule

// File: rtl/spi_irq_sts_reg.sv
// Sticky status register: set has priority over write-1-to-clear,
// and bits outside the implemented mask never hold a 1.
module spi_irq_sts_reg
    import spi_irq_pkg::*;
#(
    parameter logic [STS_W-1:0] MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STS_W-1:0] set_vec,
    input  logic             clr_wr,
    input  logic [STS_W-1:0] clr_data,
    output logic [STS_W-1:0] sts_q
);
    logic [STS_W-1:0] clr_vec;

    // Clear pattern is live only on a write strobe.
    assign clr_vec = clr_wr ? clr_data : '0;

    // Update status: clear first, then set so events win.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= ((sts_q & ~clr_vec) | set_vec) & MASK;
    end

    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q & ~MASK) == '0); // R8
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((sts_q & $past(clr_data & ~set_vec)) == '0)); // R1
    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((sts_q & $past(~clr_data & sts_q)) == $past(~clr_data & sts_q))); // R1
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_q & $past(set_vec & MASK)) == $past(set_vec & MASK))); // R10
endmodule

// File: rtl/spi_irq_collect.sv
// Top of the SPI interrupt collector: event mapping, sticky status,
// enable register and the registered combined interrupt.
// Assumes one clock domain and a synchronous active-low reset.
module spi_irq_collect
    import spi_irq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_enable,
    input  logic              slave_mode,
    input  logic [NUM_CH-1:0] ev_tx_empty,
    input  logic [NUM_CH-1:0] ev_tx_undr,
    input  logic [NUM_CH-1:0] ev_rx_full,
    input  logic              ev_rx_ovf,
    input  logic              ev_eow,
    input  logic              ev_wake,
    input  logic              test_force,
    input  logic              sts_wr,
    input  logic              en_wr,
    input  logic [STS_W-1:0]  wdata,
    output logic [STS_W-1:0]  sts_rdata,
    output logic [STS_W-1:0]  en_rdata,
    output logic              irq
);
    localparam logic [STS_W-1:0] MASK = impl_mask(NUM_CH);

    logic [STS_W-1:0] set_vec;
    logic [STS_W-1:0] sts_q;
    logic [STS_W-1:0] en_q;

    spi_irq_evt_map #(.NUM_CH(NUM_CH)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .ch_enable   (ch_enable),
        .slave_mode  (slave_mode),
        .ev_tx_empty (ev_tx_empty),
        .ev_tx_undr  (ev_tx_undr),
        .ev_rx_full  (ev_rx_full),
        .ev_rx_ovf   (ev_rx_ovf),
        .ev_eow      (ev_eow),
        .ev_wake     (ev_wake),
        .test_force  (test_force),
        .set_vec     (set_vec)
    );

    spi_irq_sts_reg #(.MASK(MASK)) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_wr   (sts_wr),
        .clr_data (wdata),
        .sts_q    (sts_q)
    );

    // Enable register: whole-word write, unimplemented bits held at 0.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= wdata & MASK;
    end

    // Combined interrupt, registered one cycle behind status and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(sts_q & en_q);
    end

    assign sts_rdata = sts_q;
    assign en_rdata  = en_q;

    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sts_rdata & en_rdata)) |=> irq); // R9
    AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(sts_rdata & en_rdata)) |=> !irq); // R9
    AST_FORCE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (test_force && !sts_wr) |=> (sts_rdata == MASK)); // R7
    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (en_rdata == ($past(wdata) & MASK))); // R6
endmodule

// File: tb/spi_irq_collect_bench.sv
module spi_irq_collect_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ch_enable = '0;
    logic        slave_mode = 1'b0;
    logic [3:0]  ev_tx_empty = '0, ev_tx_undr = '0, ev_rx_full = '0;
    logic        ev_rx_ovf = 1'b0, ev_eow = 1'b0, ev_wake = 1'b0;
    logic        test_force = 1'b0, sts_wr = 1'b0, en_wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] sts_rdata, en_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [31:0] FULL = 32'h0003_777F;

    always #4 clk = ~clk;

    spi_irq_collect u_spi_irq_collect (
        .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .slave_mode(slave_mode),
        .ev_tx_empty(ev_tx_empty), .ev_tx_undr(ev_tx_undr), .ev_rx_full(ev_rx_full),
        .ev_rx_ovf(ev_rx_ovf), .ev_eow(ev_eow), .ev_wake(ev_wake),
        .test_force(test_force), .sts_wr(sts_wr), .en_wr(en_wr), .wdata(wdata),
        .sts_rdata(sts_rdata), .en_rdata(en_rdata), .irq(irq)
    );

    function automatic bit is_impl(input int b);
        return (b < 16 && ((b % 4) != 3 || b == 3)) || b == 16 || b == 17;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        ev_tx_empty = '0; ev_tx_undr = '0; ev_rx_full = '0;
        ev_rx_ovf = 1'b0; ev_eow = 1'b0; ev_wake = 1'b0;
        test_force = 1'b0; sts_wr = 1'b0; en_wr = 1'b0; wdata = '0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        idle(); sts_wr = 1'b1; wdata = '1; tick(); idle();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        idle();
        @(negedge clk); tick(); tick();
        rst_n = 1'b1;
        // R11 reset state
        chk("R11 status", sts_rdata, 32'h0);
        chk("R11 enable", en_rdata, 32'h0);
        chk("R11 irq", {31'b0, irq}, 32'h0);

        // R2 / R5 lane sweep: each channel, each event type, enabled or not
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 3; k++) begin
                for (int en = 0; en < 2; en++) begin
                    ch_enable = (en != 0) ? 4'(1 << c) : ~4'(1 << c);
                    if (k == 0) ev_tx_empty = 4'(1 << c);
                    if (k == 1) ev_tx_undr  = 4'(1 << c);
                    if (k == 2) ev_rx_full  = 4'(1 << c);
                    tick(); idle();
                    chk((en != 0) ? "R2 lane bit" : "R5 disabled channel",
                        sts_rdata, (en != 0) ? 32'(1) << (4*c + k) : 32'h0);
                    tick();
                    chk("R2 sticky", sts_rdata, (en != 0) ? 32'(1) << (4*c + k) : 32'h0);
                    clear_all();
                    chk("R1 cleared", sts_rdata, 32'h0);
                end
            end
        end

        // R3 overflow gating over slave mode x channel 0 enable
        for (int s = 0; s < 2; s++) begin
            for (int e = 0; e < 2; e++) begin
                slave_mode = s[0]; ch_enable = {3'b111, e[0]}; ev_rx_ovf = 1'b1;
                tick(); idle();
                chk("R3 overflow", sts_rdata, (s == 1 && e == 1) ? 32'h8 : 32'h0);
                clear_all();
            end
        end
        slave_mode = 1'b0;

        // R4 module-wide events with all channels disabled
        ch_enable = '0; ev_eow = 1'b1;
        tick(); idle();
        chk("R4 end of word count", sts_rdata, 32'h0002_0000);
        ev_wake = 1'b1;
        tick(); idle();
        chk("R4 wake-up", sts_rdata, 32'h0003_0000);
        clear_all();

        // R7 force, R1 partial clears, R8 unimplemented bits
        test_force = 1'b1; tick(); idle();
        chk("R7 force all", sts_rdata, FULL);
        sts_wr = 1'b1; wdata = 32'h0; tick(); idle();
        chk("R1 write zero no effect", sts_rdata, FULL);
        sts_wr = 1'b1; wdata = 32'h0001_000F; tick(); idle();
        chk("R1 partial clear", sts_rdata, FULL & ~32'h0001_000F);
        sts_wr = 1'b1; wdata = 32'hFFFC_8880; tick(); idle();
        chk("R8 unimplemented write", sts_rdata, FULL & ~32'h0001_000F);
        clear_all();

        // R6 enable register readback
        en_wr = 1'b1; wdata = 32'hFFFF_FFFF; tick(); idle();
        chk("R6 enable mask", en_rdata, FULL);
        en_wr = 1'b1; wdata = 32'h0002_0104; tick(); idle();
        chk("R6 enable pattern", en_rdata, 32'h0002_0104);

        // R9 interrupt sweep over every enable position
        for (int b = 0; b < 32; b++) begin
            en_wr = 1'b1; wdata = 32'(1) << b; test_force = 1'b1;
            tick(); idle();
            chk("R9 irq lag", {31'b0, irq}, 32'h0);
            tick();
            chk("R9 irq level", {31'b0, irq}, {31'b0, is_impl(b)});
            sts_wr = 1'b1; en_wr = 1'b1; wdata = '1;
            tick(); idle();
            en_wr = 1'b1; wdata = '0; tick(); idle();
            chk("R9 irq drop", {31'b0, irq}, 32'h0);
        end

        // R9 clearing the pending bit drops irq one cycle later
        en_wr = 1'b1; wdata = 32'h0000_0010; tick(); idle();
        ch_enable = 4'b0010; ev_tx_empty = 4'b0010; tick(); idle();
        tick();
        chk("R9 irq from event", {31'b0, irq}, 32'h1);
        sts_wr = 1'b1; wdata = 32'h10; tick(); idle();
        chk("R9 irq still high", {31'b0, irq}, 32'h1);
        tick();
        chk("R9 irq after clear", {31'b0, irq}, 32'h0);

        // R10 event beats a same-cycle clear
        ch_enable = 4'b0011; ev_tx_empty = 4'b0011; tick(); idle();
        chk("R10 setup", sts_rdata, 32'h11);
        ev_tx_empty = 4'b0001; sts_wr = 1'b1; wdata = 32'h11; tick(); idle();
        chk("R10 event wins", sts_rdata, 32'h01);
        ev_eow = 1'b1; sts_wr = 1'b1; wdata = 32'h0002_0001; tick(); idle();
        chk("R10 eow wins", sts_rdata, 32'h0002_0000);
        clear_all();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule